// File: doc/BRIEF.md
# Video Blanking Window Generator

This block marks the active picture rectangle inside a video frame and raises a single blanking output everywhere else. The same output gates both the capture of incoming image data and the display of stored image data on a monitor. Vertical position comes from counting the falling edges of the horizontal sync input that follow each rising edge of the vertical sync input. Horizontal position comes from counting clock cycles after each horizontal sync falling edge. The horizontal window only opens on lines that lie inside the vertical window.

Four 12-bit window limits are written through a simple write port at any moment, with no regard for where the raster currently is. Each write lands in a shadow copy; all shadow copies are moved to the working copies together at the next vertical sync edge, so every frame is drawn with one coherent set of limits.

Top module: `blank_gen`

## Requirements
- R1: After reset every working limit is 0, so blank_o is 1 from the first cycle after reset until new limits are committed.
- R2: blank_o is 0 only when line count is in [LINE_BEG, LINE_END) and pixel count is in [PIX_BEG, PIX_END); otherwise it is 1. It is a function of registered state, valid in the cycle after the clock edge that updates a counter.
- R3: A rising edge of vd_i (vd_i 1 in a cycle where it was 0 in the previous cycle) sets the line count to 0; each falling edge of hd_i (hd_i 0 where it was 1 the cycle before) then adds one. A vd_i edge wins over an hd_i edge in the same cycle.
- R4: The line count stops at 4095 and does not wrap, until the next vd_i rising edge.
- R5: The pixel count is set to 0 by each hd_i falling edge, otherwise grows by one every clock cycle, and stops at 4095.
- R6: A write (wr_en_i 1) changes only the shadow copy; blank_o follows the previous working limits until the next vd_i rising edge, after which it follows the written values.
- R7: A write in the same cycle as a vd_i rising edge is not committed by that edge; it takes effect at the following vd_i rising edge.
- R8: wr_addr_i selects the limit: 0 = LINE_BEG, 1 = LINE_END, 2 = PIX_BEG, 3 = PIX_END; wr_data_i bits 11:0 give the value.
- R9: Holding vd_i at 1 for many cycles counts as one edge: hd_i falling edges during that time still advance the line count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vd_i | input | 1 | Vertical sync, frame starts on its rising edge |
| hd_i | input | 1 | Horizontal sync, line starts on its falling edge |
| wr_en_i | input | 1 | Write strobe for a window limit |
| wr_addr_i | input | 2 | Limit select (see R8) |
| wr_data_i | input | 12 | Limit value |
| blank_o | output | 1 | 1 = outside active picture, 0 = active picture |

## Verification
Every internal fault here surfaces only through blank_o, so the bench follows the frame cycle by cycle and compares blank_o against the window expected from the edges it drove. A line counter off by one shifts the active band by a whole line, seen at the first line boundary after a frame start; a pixel counter fault shifts the left or right edge within the same line. A premature commit of shadow limits shows as a changed window on the very next line after a write, while a counter that wraps instead of stopping reopens the window at the top or left long after it should stay closed.

// File: rtl/bg_pkg.sv
package bg_pkg;
   localparam int unsigned LIM_COUNT = 4;
   localparam int unsigned LIM_AW    = $clog2(LIM_COUNT);

   typedef enum logic [LIM_AW-1:0] {
      LIM_LINE_BEG = 2'd0,
      LIM_LINE_END = 2'd1,
      LIM_PIX_BEG  = 2'd2,
      LIM_PIX_END  = 2'd3
   } lim_sel_e;
endpackage

// File: rtl/bg_edge.sv
module bg_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic pulse_o
);
   logic sig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig_i;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse_o = sig_i & ~sig_q;
      end else begin : g_fall
         assign pulse_o = ~sig_i & sig_q;
      end
   endgenerate
endmodule

// File: rtl/bg_sat_counter.sv
module bg_sat_counter #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_width
         $error("bg_sat_counter: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_o <= '0;
      else if (clear_i)               cnt_o <= '0;
      else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/bg_range.sv
module bg_range #(
   parameter int unsigned W = 12
) (
   input  logic [W-1:0] val_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic         inside_o
);
   assign inside_o = (val_i >= lo_i) && (val_i < hi_i);
endmodule

// File: rtl/bg_limits.sv
module bg_limits
   import bg_pkg::*;
#(
   parameter int unsigned        W     = 12,
   parameter logic [W-1:0]       RST_V = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [LIM_AW-1:0]      wr_addr_i,
   input  logic [W-1:0]           wr_data_i,
   input  logic                   commit_i,
   output logic [LIM_COUNT*W-1:0] shd_flat_o,
   output logic [LIM_COUNT*W-1:0] act_flat_o
);
   generate
      for (genvar i = 0; i < LIM_COUNT; i++) begin : g_lim
         logic [W-1:0] shd_q;
         logic [W-1:0] act_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shd_q <= RST_V;
               act_q <= RST_V;
            end else begin
               if (wr_en_i && wr_addr_i == LIM_AW'(i)) shd_q <= wr_data_i;
               if (commit_i)                          act_q <= shd_q;
            end
         end

         assign shd_flat_o[i*W +: W] = shd_q;
         assign act_flat_o[i*W +: W] = act_q;
      end
   endgenerate
endmodule

// File: rtl/blank_gen.sv
module blank_gen
   import bg_pkg::*;
#(
   parameter int unsigned CNT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vd_i,
   input  logic              hd_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   output logic              blank_o
);
   localparam int unsigned FLAT_W = LIM_COUNT * CNT_W;

   generate
      if (CNT_W < 4 || CNT_W > 16) begin : g_bad_cnt
         $error("blank_gen: CNT_W out of supported range 4..16");
      end
      if (LIM_AW != 2) begin : g_bad_aw
         $error("blank_gen: limit address width must be 2");
      end
   endgenerate

   logic              vd_evt;
   logic              hd_fall;
   logic [CNT_W-1:0]  line_cnt;
   logic [CNT_W-1:0]  pix_cnt;
   logic [FLAT_W-1:0] shd_flat;
   logic [FLAT_W-1:0] act_flat;
   logic              v_inside;
   logic              h_inside;

   bg_edge #(.RISING(1'b1)) u_vd_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(vd_i), .pulse_o(vd_evt)
   );

   bg_edge #(.RISING(1'b0)) u_hd_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(hd_i), .pulse_o(hd_fall)
   );

   bg_sat_counter #(.W(CNT_W)) u_line_cnt (
      .clk(clk), .rst_n(rst_n), .clear_i(vd_evt), .inc_i(hd_fall), .cnt_o(line_cnt)
   );

   bg_sat_counter #(.W(CNT_W)) u_pix_cnt (
      .clk(clk), .rst_n(rst_n), .clear_i(hd_fall), .inc_i(1'b1), .cnt_o(pix_cnt)
   );

   bg_limits #(.W(CNT_W), .RST_V('0)) u_limits (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .commit_i(vd_evt),
      .shd_flat_o(shd_flat), .act_flat_o(act_flat)
   );

   bg_range #(.W(CNT_W)) u_v_range (
      .val_i(line_cnt),
      .lo_i(act_flat[LIM_LINE_BEG*CNT_W +: CNT_W]),
      .hi_i(act_flat[LIM_LINE_END*CNT_W +: CNT_W]),
      .inside_o(v_inside)
   );

   bg_range #(.W(CNT_W)) u_h_range (
      .val_i(pix_cnt),
      .lo_i(act_flat[LIM_PIX_BEG*CNT_W +: CNT_W]),
      .hi_i(act_flat[LIM_PIX_END*CNT_W +: CNT_W]),
      .inside_o(h_inside)
   );

   assign blank_o = ~(v_inside & h_inside);
endmodule

// File: rtl/blank_gen_checker.sv
module blank_gen_checker #(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned FLAT_W = 4 * CNT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vd_evt,
   input logic              hd_fall,
   input logic [CNT_W-1:0]  line_cnt,
   input logic [CNT_W-1:0]  pix_cnt,
   input logic [FLAT_W-1:0] shd_flat,
   input logic [FLAT_W-1:0] act_flat,
   input logic              v_inside,
   input logic              blank_o
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   assert_blank_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> blank_o);

   assert_blank_outside_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !v_inside |-> blank_o);

   assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vd_evt |=> line_cnt == '0);

   assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cnt == TOP && !vd_evt) |=> line_cnt == TOP);

   assert_pix_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hd_fall |=> pix_cnt == '0);

   assert_limits_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !vd_evt |=> $stable(act_flat));

   assert_commit_old_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vd_evt |=> act_flat == $past(shd_flat));
endmodule

bind blank_gen blank_gen_checker #(.CNT_W(CNT_W), .FLAT_W(FLAT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vd_evt(vd_evt), .hd_fall(hd_fall),
   .line_cnt(line_cnt), .pix_cnt(pix_cnt), .shd_flat(shd_flat),
   .act_flat(act_flat), .v_inside(v_inside), .blank_o(blank_o)
);

// File: tb/blank_gen_test.sv
module blank_gen_test;
   localparam time PERIOD = 10ns;
   localparam int  W      = 12;
   localparam int  TOPV   = 4095;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         vd_i = 1'b0;
   logic         hd_i = 1'b0;
   logic         wr_en_i = 1'b0;
   logic [1:0]   wr_addr_i = '0;
   logic [W-1:0] wr_data_i = '0;
   logic         blank_o;

   int checks = 0;
   int errors = 0;

   // expected state, built from the requirements
   int m_line = 0, m_pix = 0;
   logic m_vd_prev = 1'b0, m_hd_prev = 1'b0;
   int m_shd [4] = '{0, 0, 0, 0};
   int m_act [4] = '{0, 0, 0, 0};

   always #(PERIOD/2) clk = ~clk;

   blank_gen #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .vd_i(vd_i), .hd_i(hd_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .blank_o(blank_o)
   );

   function automatic logic exp_blank();
      return !(m_line >= m_act[0] && m_line < m_act[1] &&
               m_pix  >= m_act[2] && m_pix  < m_act[3]);
   endfunction

   task automatic check(input string req);
      logic e;
      e = exp_blank();
      checks++;
      if (blank_o !== e) begin
         errors++;
         $display("FAIL %s line=%0d pix=%0d blank actual=%b expected=%b",
                  req, m_line, m_pix, blank_o, e);
      end
   endtask

   // called at a falling edge: checks, drives, then advances to next falling edge
   task automatic step(input string req, input logic vd, input logic hd,
                       input logic we = 1'b0, input int addr = 0, input int data = 0);
      logic ve, hf;
      check(req);
      vd_i = vd; hd_i = hd; wr_en_i = we;
      wr_addr_i = 2'(addr); wr_data_i = W'(data);
      ve = vd & !m_vd_prev;
      hf = !hd & m_hd_prev;
      if (ve) for (int k = 0; k < 4; k++) m_act[k] = m_shd[k];
      if (we) m_shd[addr] = data;
      if (ve)      m_line = 0;
      else if (hf) m_line = (m_line < TOPV) ? m_line + 1 : TOPV;
      if (hf) m_pix = 0;
      else    m_pix = (m_pix < TOPV) ? m_pix + 1 : TOPV;
      m_vd_prev = vd; m_hd_prev = hd;
      @(negedge clk);
   endtask

   task automatic line(input string req, input int len, input logic vd = 1'b0);
      step(req, vd, 1'b1);
      step(req, vd, 1'b1);
      for (int c = 0; c < len - 2; c++) step(req, vd, 1'b0);
   endtask

   task automatic frame_start(input string req);
      step(req, 1'b1, 1'b0);
      step(req, 1'b0, 1'b0);
   endtask

   task automatic write_all(input string req, input int lb, input int le,
                            input int pb, input int pe);
      step(req, 1'b0, hd_i, 1'b1, 0, lb);
      step(req, 1'b0, hd_i, 1'b1, 1, le);
      step(req, 1'b0, hd_i, 1'b1, 2, pb);
      step(req, 1'b0, hd_i, 1'b1, 3, pe);
   endtask

   task automatic t_reset();
      for (int c = 0; c < 20; c++) step("R1", 1'b0, 1'b0);
   endtask

   task automatic t_window();
      // R8: addresses 0..3 carry line begin/end and pixel begin/end
      write_all("R6", 2, 5, 3, 7);
      for (int l = 0; l < 3; l++) line("R6", 12);
      frame_start("R3");
      for (int l = 0; l < 7; l++) line("R2", 12);
      frame_start("R8");
      for (int l = 0; l < 7; l++) line("R8", 10);
   endtask

   task automatic t_shadow();
      frame_start("R6");
      line("R6", 12);
      write_all("R6", 1, 3, 0, 4);
      for (int l = 0; l < 5; l++) line("R6", 12);
      frame_start("R6");
      for (int l = 0; l < 5; l++) line("R6", 12);
   endtask

   task automatic t_same_cycle();
      line("R7", 10);
      step("R7", 1'b1, 1'b0, 1'b1, 1, 6);
      step("R7", 1'b0, 1'b0);
      for (int l = 0; l < 7; l++) line("R7", 10);
      frame_start("R7");
      for (int l = 0; l < 7; l++) line("R7", 10);
   endtask

   task automatic t_vd_hold();
      write_all("R9", 2, 4, 1, 5);
      step("R9", 1'b0, 1'b0);
      for (int l = 0; l < 6; l++) line("R9", 10, 1'b1);
      step("R9", 1'b0, 1'b0);
      for (int l = 0; l < 3; l++) line("R9", 10);
   endtask

   task automatic t_line_sat();
      write_all("R4", 0, 2, 0, 4095);
      frame_start("R4");
      for (int l = 0; l < 4100; l++) begin
         step("R4", 1'b0, 1'b1);
         step("R4", 1'b0, 1'b0);
      end
      for (int c = 0; c < 10; c++) step("R4", 1'b0, 1'b0);
   endtask

   task automatic t_pix_sat();
      write_all("R5", 0, 4095, 0, 3);
      frame_start("R5");
      line("R5", 4110);
      line("R5", 8);
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_window();
      t_shadow();
      t_same_cycle();
      t_vd_hold();
      t_line_sat();
      t_pix_sat();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule